// File: doc/BRIEF.md
# Prescaled Trigger Delay Timer

This block holds off a conversion trigger for a programmable time and then issues a one-cycle start-of-conversion pulse. A 16-bit configuration word sets the timing. A 2-bit divisor field sets a prescaler that divides the module clock by the field value plus one. The prescaler output is a tick, and a 9-bit delay field sets how many ticks pass before the start pulse.

A 5-bit fine-delay field passes through to an output code for a downstream delay line. Codes above 20 behave the same as 20, so the block presents the saturated value. The block accepts one trigger when it is idle. It captures the divisor and delay fields at that moment and counts the delay from the trigger itself. Triggers that arrive while a delay is running are ignored.

Top module: `trig_delay_timer`

## Requirements
- R1: After reset, `soc_pulse` and `busy` are 0 and the configuration word is 0, so `fine_code` reads 0.
- R2: The configuration word is laid out with the divisor in bits 15:14, the delay count in bits 13:5 and the fine-delay field in bits 4:0. It is loaded from `cfg_wdata` on a clock edge where `cfg_we` is 1.
- R3: A trigger accepted at clock edge E0 is one sampled while `busy` is 0. For it, `soc_pulse` is 1 in the cycle that follows edge E0 + (D+1)·(V+1). D is the delay count (0 to 511) and V is the divisor (0 to 3). With D = 0, the pulse comes on the first prescaler tick.
- R4: `soc_pulse` is high for exactly one clock cycle for each accepted trigger.
- R5: `busy` goes to 1 on the edge that accepts a trigger. It returns to 0 on the same edge that raises `soc_pulse`.
- R6: A trigger sampled while `busy` is 1 is ignored. This includes a trigger on the edge that raises the start pulse. Such a trigger neither changes the running delay nor produces a further pulse.
- R7: Writes to the configuration during a running delay do not change that delay. The divisor and delay count are captured when the trigger is accepted.
- R8: `fine_code` equals the fine-delay field when that field is 20 or less, and equals 20 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 16 | Configuration word to load |
| trig_in | input | 1 | Conversion trigger, sampled each edge |
| busy | output | 1 | A delay is running |
| soc_pulse | output | 1 | One-cycle start-of-conversion pulse |
| fine_code | output | 5 | Saturated fine-delay code (0 to 20) |

## Verification
The delay can finish on the very clock edge at which a new trigger is sampled. In that cycle the completion clears `busy` and raises `soc_pulse`, while the trigger looks for an idle timer. The bench holds `trig_in` high during exactly the cycle before the expected completion edge. The case passes if the pulse appears at the computed latency, `busy` is low afterwards, and no second pulse follows. A separate case drives a trigger in the middle of a run and judges it by an unchanged latency.

// File: rtl/trig_delay_timer.sv
module trig_delay_timer #(
  parameter int DIV_W    = 2,
  parameter int CNT_W    = 9,
  parameter int FINE_W   = 5,
  parameter int FINE_MAX = 20
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [DIV_W+CNT_W+FINE_W-1:0]    cfg_wdata,
  input  logic                             trig_in,
  output logic                             busy,
  output logic                             soc_pulse,
  output logic [FINE_W-1:0]                fine_code
);
  localparam int CFG_W  = DIV_W + CNT_W + FINE_W;
  localparam int CNT_LO = FINE_W;
  localparam int DIV_LO = FINE_W + CNT_W;

  logic [CFG_W-1:0] cfg;
  logic [DIV_W-1:0] div_q, pre;
  logic [CNT_W-1:0] cnt;
  logic             tick;

  wire [DIV_W-1:0]  cfg_div  = cfg[DIV_LO +: DIV_W];
  wire [CNT_W-1:0]  cfg_cnt  = cfg[CNT_LO +: CNT_W];
  wire [FINE_W-1:0] cfg_fine = cfg[FINE_W-1:0];

  assign tick      = busy && (pre == div_q);
  assign fine_code = (cfg_fine > FINE_W'(FINE_MAX)) ? FINE_W'(FINE_MAX) : cfg_fine;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg       <= '0;
      busy      <= 1'b0;
      soc_pulse <= 1'b0;
      pre       <= '0;
      cnt       <= '0;
      div_q     <= '0;
    end else begin
      soc_pulse <= 1'b0;
      if (cfg_we) cfg <= cfg_wdata;
      if (!busy) begin
        if (trig_in) begin
          busy  <= 1'b1;
          pre   <= '0;
          cnt   <= cfg_cnt;
          div_q <= cfg_div;
        end
      end else if (tick) begin
        pre <= '0;
        if (cnt == '0) begin
          busy      <= 1'b0;
          soc_pulse <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  // R4
  soc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soc_pulse |=> !soc_pulse);

  // R5
  soc_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soc_pulse) |-> ($fell(busy) && $past(busy)));

  // R5
  trig_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in && !busy) |=> busy);

  // R6
  run_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> ($stable(cnt) && $stable(div_q)));

  // R8
  fine_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fine_code <= FINE_W'(FINE_MAX));

  // R3
  prescale_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pre <= div_q));
endmodule

// File: tb/trig_delay_timer_tb.sv
module trig_delay_timer_tb_top;
  logic clk = 0, rst_n = 0, cfg_we = 0, trig_in = 0;
  logic [15:0] cfg_wdata = '0;
  logic busy, soc_pulse;
  logic [4:0] fine_code;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trig_delay_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .trig_in(trig_in), .busy(busy), .soc_pulse(soc_pulse), .fine_code(fine_code));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int dv, input int dl, input int fn);
    cfg_wdata = {dv[1:0], dl[8:0], fn[4:0]};
    cfg_we = 1;
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
  endtask

  // mode 0 plain, 1 mid-run trigger, 2 trigger on completion edge, 3 cfg write mid-run
  task automatic run(input int dv, input int dl, input int mode, output int n);
    int lat = (dl + 1) * (dv + 1);
    int pulses = 0;
    trig_in = 1;
    @(posedge clk); @(negedge clk);
    trig_in = 0;
    n = 0;
    while (!soc_pulse && n < 3000) begin
      if (mode == 1 && n == 3) trig_in = 1;
      if (mode == 1 && n == 4) trig_in = 0;
      if (mode == 2 && n == lat - 1) trig_in = 1;
      if (mode == 3 && n == 2) begin cfg_wdata = '0; cfg_we = 1; end
      if (mode == 3 && n == 3) cfg_we = 0;
      @(posedge clk); @(negedge clk);
      n++;
    end
    trig_in = 0;
    cfg_we = 0;
    if (soc_pulse) pulses++;
    chk("R5 busy low with pulse", busy, 0);
    for (int i = 0; i < lat + 8; i++) begin
      @(posedge clk); @(negedge clk);
      if (soc_pulse) pulses++;
    end
    chk("R4/R6 pulse count", pulses, 1);
  endtask

  initial begin
    int n;
    int dls[6] = '{0, 1, 2, 5, 100, 511};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 soc", soc_pulse, 0);
    chk("R1 busy", busy, 0);
    chk("R1 fine", fine_code, 0);
    for (int v = 0; v < 32; v++) begin
      wr(0, 0, v);
      chk("R8 fine saturation", fine_code, v > 20 ? 20 : v);
    end
    for (int dv = 0; dv < 4; dv++)
      for (int j = 0; j < 6; j++) begin
        wr(dv, dls[j], 0);
        run(dv, dls[j], 0, n);
        chk("R3/R2 latency", n, (dls[j] + 1) * (dv + 1));
      end
    wr(1, 10, 0);
    run(1, 10, 1, n);
    chk("R6 mid-run trigger latency", n, 22);
    wr(0, 3, 0);
    run(0, 3, 2, n);
    chk("R6 completion-edge trigger latency", n, 4);
    wr(2, 4, 0);
    run(2, 4, 3, n);
    chk("R7 config write mid-run latency", n, 15);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule